// File: doc/BRIEF.md
# Command/Response Link Transaction Sequencer with CRC Recovery

This block sequences one transaction at a time for the master end of a two-wire serial command/response link. It takes a command frame and a slave id, asks the serializer to send the frame, then classifies the decoded response event that comes back. Bit-level shifting and CRC generation and checking are done elsewhere. The block sees only whole-frame requests and response events, each carrying a tag, a CRC-good flag and a timeout flag.

There are two separate ways to recover from a CRC failure. If the master finds that a response arrived corrupted, it sends a run of idle zero clocks and then a short poll frame. The poll asks the slave to send its last response again, and the command is not executed a second time. This matters for side effects such as reading a slave FIFO. If the slave reports that the command it received was corrupted, the sequencer primes the slave, waits for a pacing interval and sends the whole command again. Each path has its own retry budget. Every outcome ends with a burst of idle zero clocks that primes the slave, followed by a one-cycle done pulse that carries a 3-bit status.

Top module: `crc_retry_seq`

## Requirements
- R1: During and after a synchronous active-high reset, `tx_valid`, `idle_valid` and `done` are low and `status` is 0.
- R2: When the block is idle, a `req_valid` pulse captures the frame and the slave id. The block then emits `tx_valid` with `tx_poll`=0 and `tx_frame` equal to the captured frame. Any `req_valid` that arrives while a transaction is in progress is ignored, and every later command send carries the original frame.
- R3: Response tags are 0 = acknowledge, 1 = busy, 2 = slave error and 3 = slave saw a bad command CRC. With a good CRC, tag 0 ends with status OK (0) and tag 2 ends with status SLAVE_ERROR (3). Status codes are OK=0, IO_ERROR=1, TIMEOUT=2 and SLAVE_ERROR=3.
- R4: A good-CRC busy response (tag 1) sends nothing, spends no retry budget, and leaves the block waiting for the next response event.
- R5: A response with a bad CRC and no timeout causes an `idle_valid` pulse with `idle_count`=EPOLL_ZEROS (50). The next cycle carries `tx_valid` with `tx_poll`=1 and a frame holding the slave id in bits [4:3], opcode 3'b011 in bits [2:0] and zeros in all higher bits. The command is not resent.
- R6: At most MAX_POLLS (11) resend polls follow one command send. A bad-CRC response that arrives after that many polls ends the transaction with IO_ERROR, and the command is not reissued.
- R7: A good-CRC tag-3 response primes the slave (`idle_count`=PRIME_ZEROS) and then sends the whole command again. The resend's `tx_valid` comes PACE_CYCLES+1 cycles after the prime pulse. The poll budget starts again from zero for each send.
- R8: At most MAX_SENDS (10) command sends are made per request. A tag-3 response to the last of them ends with IO_ERROR.
- R9: A response with the timeout flag set ends with TIMEOUT, whatever its tag and CRC flag, and causes no poll or resend.
- R10: Every ending is preceded, in the cycle just before `done`, by an `idle_valid` pulse with `idle_count`=PRIME_ZEROS (16).
- R11: `done` is a single-cycle pulse that carries the final status. Both retry budgets are cleared when a new request is accepted, so a request that follows an exhausted one gets the full budgets again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transaction (taken only when idle) |
| req_frame | input | FRAME_W | Command frame to send |
| req_slave | input | SID_W | Target slave id |
| rsp_valid | input | 1 | A response event is present |
| rsp_tag | input | 2 | Decoded response tag |
| rsp_crc_ok | input | 1 | Response CRC checked good |
| rsp_timeout | input | 1 | No response arrived in time |
| tx_valid | output | 1 | One-cycle request to serialize `tx_frame` |
| tx_frame | output | FRAME_W | Frame to serialize |
| tx_poll | output | 1 | Frame is a resend-response poll |
| idle_valid | output | 1 | One-cycle request to clock idle zeros |
| idle_count | output | ZW | Number of idle zero clocks |
| done | output | 1 | Transaction finished (one cycle) |
| status | output | 3 | Final status code |

## Verification
A timeout and a response-CRC failure can be flagged in the same response event, and the command-CRC tag can come with them. The classifier has to choose one recovery path in that cycle. The bench drives events in which both flags are set, once with tag 0 and once with tag 3 and a bad CRC. It judges the outcome by requiring status TIMEOUT with exactly one command send, no poll, no resend, and the prime pulse right before `done`. A busy event followed at once by a bad-CRC event in the next cycle checks that the two are handled one after the other, with neither lost.

// File: rtl/crc_retry_pkg.sv
package crc_retry_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_IO_ERR  = 3'd1,
    ST_TIMEOUT = 3'd2,
    ST_SLV_ERR = 3'd3
  } status_e;

  typedef enum logic [2:0] {
    RC_NONE,
    RC_ACK,
    RC_BUSY,
    RC_SLVERR,
    RC_CMDCRC,
    RC_BADCRC,
    RC_TIMEOUT
  } rsp_class_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_WAIT,
    S_EZERO,
    S_POLL,
    S_PRIME,
    S_PACE,
    S_FIN
  } seq_state_e;

  localparam logic [1:0] TAG_ACK    = 2'd0;
  localparam logic [1:0] TAG_BUSY   = 2'd1;
  localparam logic [1:0] TAG_ERR    = 2'd2;
  localparam logic [1:0] TAG_CMDCRC = 2'd3;

  localparam logic [2:0] POLL_OPCODE = 3'b011;

endpackage

// File: rtl/crc_retry_rsp_class.sv
module crc_retry_rsp_class
  import crc_retry_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] tag,
  input  logic       crc_ok,
  input  logic       timeout,
  output rsp_class_e cls
);

  // Priority: timeout, then bad CRC, then the tag itself.
  always_comb begin
    if (!valid) begin
      cls = RC_NONE;
    end else if (timeout) begin
      cls = RC_TIMEOUT;
    end else if (!crc_ok) begin
      cls = RC_BADCRC;
    end else begin
      case (tag)
        TAG_ACK:  cls = RC_ACK;
        TAG_BUSY: cls = RC_BUSY;
        TAG_ERR:  cls = RC_SLVERR;
        default:  cls = RC_CMDCRC;
      endcase
    end
  end

endmodule

// File: rtl/crc_retry_counter.sv
module crc_retry_counter #(
  parameter  int LIMIT = 10,
  localparam int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         at_limit
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && (count != W'(LIMIT))) begin
      count <= count + 1'b1;
    end
  end

  assign at_limit = (count == W'(LIMIT));

endmodule

// File: rtl/crc_retry_pacer.sv
module crc_retry_pacer #(
  parameter  int CYCLES = 2500,
  localparam int W      = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= W'(CYCLES - 1);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/crc_retry_poll_frame.sv
module crc_retry_poll_frame
  import crc_retry_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int SID_W   = 2
) (
  input  logic [SID_W-1:0]   slave,
  output logic [FRAME_W-1:0] frame
);

  localparam int POLL_W = SID_W + 3;

  generate
    if (FRAME_W >= POLL_W) begin : g_fit
      assign frame = FRAME_W'({slave, POLL_OPCODE});
    end else begin : g_trunc
      logic [POLL_W-1:0] full;
      assign full  = {slave, POLL_OPCODE};
      assign frame = full[FRAME_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/crc_retry_seq.sv
module crc_retry_seq
  import crc_retry_pkg::*;
#(
  parameter  int FRAME_W     = 24,
  parameter  int SID_W       = 2,
  parameter  int MAX_SENDS   = 10,
  parameter  int MAX_POLLS   = 11,
  parameter  int EPOLL_ZEROS = 50,
  parameter  int PRIME_ZEROS = 16,
  parameter  int PACE_CYCLES = 2500,
  localparam int ZMAX        = (EPOLL_ZEROS > PRIME_ZEROS) ? EPOLL_ZEROS : PRIME_ZEROS,
  localparam int ZW          = $clog2(ZMAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [FRAME_W-1:0] req_frame,
  input  logic [SID_W-1:0]   req_slave,
  input  logic               rsp_valid,
  input  logic [1:0]         rsp_tag,
  input  logic               rsp_crc_ok,
  input  logic               rsp_timeout,
  output logic               tx_valid,
  output logic [FRAME_W-1:0] tx_frame,
  output logic               tx_poll,
  output logic               idle_valid,
  output logic [ZW-1:0]      idle_count,
  output logic               done,
  output logic [2:0]         status
);

  localparam int SEND_W = $clog2(MAX_SENDS + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  seq_state_e         state;
  logic [FRAME_W-1:0] cmd_q;
  logic [SID_W-1:0]   slave_q;
  logic               resend_q;
  status_e            result_q;

  rsp_class_e         cls;
  logic [FRAME_W-1:0] poll_frame;
  logic [SEND_W-1:0]  send_cnt;
  logic [POLL_W-1:0]  poll_cnt;
  logic               sends_spent;
  logic               polls_spent;
  logic               pace_done;

  logic accept;
  logic send_clr, send_inc, poll_clr, poll_inc, pace_load;

  assign accept    = (state == S_IDLE) && req_valid;
  assign send_clr  = accept;
  assign send_inc  = (state == S_SEND);
  assign poll_clr  = accept || (state == S_SEND);
  assign poll_inc  = (state == S_POLL);
  assign pace_load = (state == S_PRIME) && resend_q;

  crc_retry_rsp_class u_class (
    .valid   (rsp_valid && (state == S_WAIT)),
    .tag     (rsp_tag),
    .crc_ok  (rsp_crc_ok),
    .timeout (rsp_timeout),
    .cls     (cls)
  );

  crc_retry_poll_frame #(
    .FRAME_W (FRAME_W),
    .SID_W   (SID_W)
  ) u_poll (
    .slave (slave_q),
    .frame (poll_frame)
  );

  crc_retry_counter #(.LIMIT(MAX_SENDS)) u_send_budget (
    .clk      (clk),
    .rst      (rst),
    .clr      (send_clr),
    .inc      (send_inc),
    .count    (send_cnt),
    .at_limit (sends_spent)
  );

  crc_retry_counter #(.LIMIT(MAX_POLLS)) u_poll_budget (
    .clk      (clk),
    .rst      (rst),
    .clr      (poll_clr),
    .inc      (poll_inc),
    .count    (poll_cnt),
    .at_limit (polls_spent)
  );

  crc_retry_pacer #(.CYCLES(PACE_CYCLES)) u_pacer (
    .clk     (clk),
    .rst     (rst),
    .load    (pace_load),
    .expired (pace_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cmd_q      <= '0;
      slave_q    <= '0;
      resend_q   <= 1'b0;
      result_q   <= ST_OK;
      tx_valid   <= 1'b0;
      tx_frame   <= '0;
      tx_poll    <= 1'b0;
      idle_valid <= 1'b0;
      idle_count <= '0;
      done       <= 1'b0;
      status     <= ST_OK;
    end else begin
      tx_valid   <= 1'b0;
      idle_valid <= 1'b0;
      done       <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            cmd_q   <= req_frame;
            slave_q <= req_slave;
            state   <= S_SEND;
          end
        end
        S_SEND: begin
          tx_valid <= 1'b1;
          tx_frame <= cmd_q;
          tx_poll  <= 1'b0;
          state    <= S_WAIT;
        end
        S_WAIT: begin
          case (cls)
            RC_TIMEOUT: begin
              result_q <= ST_TIMEOUT;
              resend_q <= 1'b0;
              state    <= S_PRIME;
            end
            RC_BADCRC: begin
              if (polls_spent) begin
                result_q <= ST_IO_ERR;
                resend_q <= 1'b0;
                state    <= S_PRIME;
              end else begin
                state <= S_EZERO;
              end
            end
            RC_ACK: begin
              result_q <= ST_OK;
              resend_q <= 1'b0;
              state    <= S_PRIME;
            end
            RC_SLVERR: begin
              result_q <= ST_SLV_ERR;
              resend_q <= 1'b0;
              state    <= S_PRIME;
            end
            RC_CMDCRC: begin
              if (sends_spent) begin
                result_q <= ST_IO_ERR;
                resend_q <= 1'b0;
              end else begin
                resend_q <= 1'b1;
              end
              state <= S_PRIME;
            end
            default: ;
          endcase
        end
        S_EZERO: begin
          idle_valid <= 1'b1;
          idle_count <= ZW'(EPOLL_ZEROS);
          state      <= S_POLL;
        end
        S_POLL: begin
          tx_valid <= 1'b1;
          tx_frame <= poll_frame;
          tx_poll  <= 1'b1;
          state    <= S_WAIT;
        end
        S_PRIME: begin
          idle_valid <= 1'b1;
          idle_count <= ZW'(PRIME_ZEROS);
          resend_q   <= 1'b0;
          state      <= resend_q ? S_PACE : S_FIN;
        end
        S_PACE: begin
          if (pace_done) state <= S_SEND;
        end
        S_FIN: begin
          done   <= 1'b1;
          status <= result_q;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/crc_retry_seq_chk.sv
module crc_retry_seq_chk #(
  parameter int FRAME_W     = 24,
  parameter int SID_W       = 2,
  parameter int MAX_SENDS   = 10,
  parameter int EPOLL_ZEROS = 50,
  parameter int PRIME_ZEROS = 16,
  parameter int ZW          = 6,
  parameter int SEND_W      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               rsp_valid,
  input logic               rsp_timeout,
  input logic               waiting,
  input logic               tx_valid,
  input logic [FRAME_W-1:0] tx_frame,
  input logic               tx_poll,
  input logic               idle_valid,
  input logic [ZW-1:0]      idle_count,
  input logic               done,
  input logic [2:0]         status,
  input logic [SEND_W-1:0]  send_cnt
);

  assert_tx_idle_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && idle_valid));

  assert_poll_after_zeros_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_poll) |-> ($past(idle_valid) && ($past(idle_count) == ZW'(EPOLL_ZEROS))));

  assert_poll_layout_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_poll) |-> ((tx_frame[2:0] == 3'b011) && ((tx_frame >> (SID_W + 3)) == '0)));

  assert_prime_before_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(idle_valid) && ($past(idle_count) == ZW'(PRIME_ZEROS))));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_timeout_no_retry_R9: assert property (@(posedge clk) disable iff (rst)
    (waiting && rsp_valid && rsp_timeout) |=> ##1
      (idle_valid && (idle_count == ZW'(PRIME_ZEROS)) && !tx_valid));

  assert_send_budget_R8: assert property (@(posedge clk) disable iff (rst)
    send_cnt <= SEND_W'(MAX_SENDS));

  assert_status_code_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (status <= 3'd3));

endmodule

bind crc_retry_seq crc_retry_seq_chk #(
  .FRAME_W     (FRAME_W),
  .SID_W       (SID_W),
  .MAX_SENDS   (MAX_SENDS),
  .EPOLL_ZEROS (EPOLL_ZEROS),
  .PRIME_ZEROS (PRIME_ZEROS),
  .ZW          (ZW),
  .SEND_W      (SEND_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rsp_valid   (rsp_valid),
  .rsp_timeout (rsp_timeout),
  .waiting     (state == S_WAIT),
  .tx_valid    (tx_valid),
  .tx_frame    (tx_frame),
  .tx_poll     (tx_poll),
  .idle_valid  (idle_valid),
  .idle_count  (idle_count),
  .done        (done),
  .status      (status),
  .send_cnt    (send_cnt)
);

// File: tb/tb_crc_retry_seq.sv
`timescale 1ns/1ps
module tb_crc_retry_seq;

  localparam int FRAME_W = 24;
  localparam int SID_W   = 2;
  localparam int SENDS   = 10;
  localparam int POLLS   = 11;
  localparam int EZ      = 50;
  localparam int PZ      = 16;
  localparam int PACE    = 64;
  localparam int ZW      = 6;

  // response nibble {timeout, crc_ok, tag}
  localparam logic [3:0] R_ACK  = 4'h4;
  localparam logic [3:0] R_BUSY = 4'h5;
  localparam logic [3:0] R_BAD  = 4'h0;
  localparam logic [3:0] R_ERRC = 4'h7;

  // {script[15:0], status[2:0], sends[3:0], polls[3:0], slave[1:0]}
  localparam logic [28:0] VEC [0:8] = '{
    {16'h4444, 3'd0, 4'd1, 4'd0, 2'd1},
    {16'h6444, 3'd3, 4'd1, 4'd0, 2'd2},
    {16'h5444, 3'd0, 4'd1, 4'd0, 2'd0},
    {16'h0444, 3'd0, 4'd1, 4'd1, 2'd3},
    {16'h7444, 3'd0, 4'd2, 4'd0, 2'd1},
    {16'h8444, 3'd2, 4'd1, 4'd0, 2'd0},
    {16'hB444, 3'd2, 4'd1, 4'd0, 2'd2},
    {16'h0074, 3'd0, 4'd2, 4'd2, 2'd2},
    {16'h5060, 3'd3, 4'd1, 4'd1, 2'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic               req_valid = 1'b0;
  logic [FRAME_W-1:0] req_frame = '0;
  logic [SID_W-1:0]   req_slave = '0;
  logic               rsp_valid = 1'b0;
  logic [1:0]         rsp_tag = '0;
  logic               rsp_crc_ok = 1'b0;
  logic               rsp_timeout = 1'b0;
  logic               tx_valid;
  logic [FRAME_W-1:0] tx_frame;
  logic               tx_poll;
  logic               idle_valid;
  logic [ZW-1:0]      idle_count;
  logic               done;
  logic [2:0]         status;

  crc_retry_seq #(
    .FRAME_W(FRAME_W), .SID_W(SID_W), .MAX_SENDS(SENDS), .MAX_POLLS(POLLS),
    .EPOLL_ZEROS(EZ), .PRIME_ZEROS(PZ), .PACE_CYCLES(PACE)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_frame(req_frame),
    .req_slave(req_slave), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_crc_ok(rsp_crc_ok), .rsp_timeout(rsp_timeout), .tx_valid(tx_valid),
    .tx_frame(tx_frame), .tx_poll(tx_poll), .idle_valid(idle_valid),
    .idle_count(idle_count), .done(done), .status(status)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  int cyc = 0;
  int n_cmd = 0;
  int n_poll = 0;
  int last_prime = 0;
  bit prev_prime = 0;
  bit prev_ezero = 0;
  bit prev_done  = 0;
  logic [FRAME_W-1:0] exp_frame = '0;
  logic [SID_W-1:0]   exp_slave = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (tx_valid && !tx_poll) begin
        n_cmd++;
        chk(tx_frame == exp_frame, "R2 command frame", tx_frame, exp_frame);
        if (n_cmd > 1)
          chk((cyc - last_prime) == PACE + 1, "R7 pacing gap", cyc - last_prime, PACE + 1);
      end
      if (tx_valid && tx_poll) begin
        n_poll++;
        chk(tx_frame == FRAME_W'({exp_slave, 3'b011}), "R5 poll frame", tx_frame,
            FRAME_W'({exp_slave, 3'b011}));
        chk(prev_ezero, "R5 zeros before poll", prev_ezero, 1);
      end
      if (done) chk(prev_prime, "R10 prime before done", prev_prime, 1);
      if (prev_done) chk(!done, "R11 done single pulse", done, 0);
      if (idle_valid && idle_count == ZW'(PZ)) last_prime = cyc;
      prev_prime = idle_valid && (idle_count == ZW'(PZ));
      prev_ezero = idle_valid && (idle_count == ZW'(EZ));
      prev_done  = done;
    end
  end

  // mode 0: script then ACK; 1: always bad CRC; 2: always command-CRC tag
  task automatic run(input logic [FRAME_W-1:0] fr, input logic [SID_W-1:0] sid,
                     input logic [15:0] script, input int mode, input bit inject,
                     input int exp_st, input int exp_cmd, input int exp_poll,
                     input string name);
    int idx = 0;
    bit fin = 0;
    bit fire = 0;
    bit injected = 0;
    logic [3:0] r;
    int got_st = -1;
    exp_frame = fr;
    exp_slave = sid;
    n_cmd = 0;
    n_poll = 0;
    @(negedge clk);
    req_valid = 1'b1; req_frame = fr; req_slave = sid;
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin) begin
      @(negedge clk);
      rsp_valid = 1'b0;
      req_valid = 1'b0;
      if (tx_valid || fire) begin
        fire = 0;
        if (mode == 1)      r = R_BAD;
        else if (mode == 2) r = R_ERRC;
        else if (idx < 4)   r = script[15 - 4*idx -: 4];
        else                r = R_ACK;
        {rsp_timeout, rsp_crc_ok, rsp_tag} = r;
        rsp_valid = 1'b1;
        if (r == R_BUSY) fire = 1;
        idx++;
        if (inject && !injected) begin
          injected = 1;
          req_valid = 1'b1;
          req_frame = ~fr;
          req_slave = ~sid;
        end
      end
      if (done) begin
        fin = 1;
        got_st = int'(status);
      end
    end
    @(negedge clk);
    chk(got_st == exp_st, {name, " status"}, got_st, exp_st);
    chk(n_cmd == exp_cmd, {name, " command sends"}, n_cmd, exp_cmd);
    chk(n_poll == exp_poll, {name, " resend polls"}, n_poll, exp_poll);
    repeat (3) @(negedge clk);
  endtask

  function automatic string vname(input int i);
    case (i)
      0: return "R3 ack";
      1: return "R3 slave error";
      2: return "R4 busy then ack";
      3: return "R5 bad crc then ack";
      4: return "R7 command crc then ack";
      5: return "R9 timeout";
      6: return "R9 timeout with bad crc and tag3";
      7: return "R5 R7 polls then resend";
      default: return "R4 R5 busy bad crc slave error";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!tx_valid && !idle_valid && !done, "R1 outputs in reset",
        {tx_valid, idle_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !idle_valid && !done, "R1 outputs after reset",
        {tx_valid, idle_valid, done}, 0);
    chk(status == 3'd0, "R1 status after reset", status, 0);

    for (int i = 0; i < 9; i++) begin
      run(FRAME_W'(24'h5A0000 + i * 24'h111), VEC[i][1:0], VEC[i][28:13], 0, 0,
          int'(VEC[i][12:10]), int'(VEC[i][9:6]), int'(VEC[i][5:2]), vname(i));
    end

    run(24'hC0FFEE, 2'd2, 16'h0000, 1, 0, 1, 1, POLLS, "R6 poll budget exhausted");
    run(24'h13579B, 2'd1, 16'h0000, 2, 0, 1, SENDS, 0, "R8 send budget exhausted");
    run(24'h2468AC, 2'd3, 16'h0000, 1, 0, 1, 1, POLLS, "R11 poll budget cleared");
    run(24'h0F0F0F, 2'd0, 16'h7444, 0, 0, 0, 2, 0, "R11 send budget cleared");
    run(24'hA5A5A5, 2'd1, 16'h7444, 0, 1, 0, 2, 0, "R2 request ignored while busy");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule